// File: doc/BRIEF.md
# Ring-Wake and Power-State Control

This standby-domain block watches an active-low ring-indicator line and wakes the system when a ring arrives. The line is synchronized and then debounced. The settling interval is picked at run time from three fixed lengths. A settled high-to-low transition can raise a power-management event pulse, a power-switch-out event pulse, or both. Each of the two events has its own enable.

The block also drives two active-low energy-saving control pins. A small level table sets each pin's level separately for three system conditions: S3 sleep, S5 soft-off, and after AC loss. A master enable gates the whole pin function. While the system is working, or while the master enable is off, both pins rest high.

A four-entry register port holds the settings and two status flags. The first flag records AC loss. The second records a return from S3. Both flags are cleared by writing 1 to them.

Top module: `ringwake_pwrctl`

## Requirements
- R1: After reset the control register (address 0) reads 0x10. The level register (address 1) reads 0x0F. The status register (address 2) reads 0x01. Address 3 reads 0x00, and writes to address 3 change nothing. Both control pins are high and both event outputs are low.
- R2: The control register holds: bit 0 master enable, bit 1 power-management event enable, bit 2 power-switch-out event enable, bits 5:4 debounce select. The debounce interval is counted in ticks of TICK_DIV clocks (1 µs with the default parameters). Select 01 needs SHORT_TICKS ticks, 10 needs MID_TICKS ticks, and 11 needs LONG_TICKS ticks. The debounced level follows the synchronized ring input only after the input has differed from it for that many ticks.
- R3: A low glitch shorter than the selected interval produces no event.
- R4: Select 00 bypasses the debounce. The debounced level follows the synchronized input on the next clock, so an event appears on the fourth rising edge after the input falls.
- R5: When bit 1 is set, each debounced falling edge produces exactly one single-cycle pulse on pme_evt. A rising edge produces none. When bit 1 is clear, no pulse appears.
- R6: When bit 2 is set, each debounced falling edge produces exactly one single-cycle pulse on pso_evt. This is independent of bit 1. When both bits are set, the two pulses occur in the same cycle.
- R7: The power state is encoded as 00 working, 01 S3, 10 S5, 11 after AC loss. When the master enable is clear, or the state is 00, ctl_n reads 11 one clock later.
- R8: When the master enable is set, ctl_n[k] takes a bit of the level register one clock later. In state 01 it takes bit k, in state 10 bit 2+k, and in state 11 bit 4+k.
- R9: Status bit 0 (AC lost) resets to 1. Writing 1 to it clears it, and writing 0 leaves it unchanged. It is set when the power state enters 11, and this set wins over a clear in the same cycle.
- R10: Status bit 1 (back from S3) is set when the power state goes from 01 to 00. It is not set by any other transition, and writing 1 to it clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_n | input | 1 | Asynchronous active-low ring indicator |
| pwr_state | input | 2 | System power state (00 working, 01 S3, 10 S5, 11 after AC loss) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| pme_evt | output | 1 | Power-management event pulse |
| pso_evt | output | 1 | Power-switch-out event pulse |
| ctl_n | output | 2 | Active-low energy-saving control pins |

## Verification
Two functions can act on the same status bit in one cycle: the hardware setting AC lost on entry to state 11, and a software write-1-to-clear. The bench drives the state into 11 in the same cycle as a clearing write to address 2, then reads the flag back. The set must win, so the flag must read 1. The two event outputs can also fire together. The bench sweeps every debounce select against every enable pair and checks that enabled events start on the same, arithmetically bounded cycle.

// File: rtl/ringwake_pkg.sv
package ringwake_pkg;

    typedef enum logic [1:0] {
        PS_WORK   = 2'b00,
        PS_S3     = 2'b01,
        PS_S5     = 2'b10,
        PS_ACLOSS = 2'b11
    } pwr_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LEVEL = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;

    localparam logic [1:0] DBSEL_BYPASS = 2'b00;
    localparam logic [1:0] DBSEL_SHORT  = 2'b01;
    localparam logic [1:0] DBSEL_MID    = 2'b10;

    typedef struct packed {
        logic [1:0] dbsel;
        logic       pso_en;
        logic       pme_en;
        logic       master_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{dbsel: DBSEL_SHORT, pso_en: 1'b0,
                                   pme_en: 1'b0, master_en: 1'b0};
    localparam logic [5:0] LEVEL_RST = 6'b00_1111;

endpackage

// File: rtl/ringwake_tick.sv
module ringwake_tick #(
    parameter int TICK_DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_s;

    tick_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (s_q.cnt == LAST) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/ringwake_debounce.sv
module ringwake_debounce
    import ringwake_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_TICKS = 200,
    parameter int MID_TICKS   = 2000,
    parameter int LONG_TICKS  = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_n,
    input  logic       tick,
    input  logic [1:0] dbsel,
    output logic       ring_sync,
    output logic       ring_deb
);
    localparam int CNT_W = $clog2(LONG_TICKS + 1);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_MID   = CNT_W'(MID_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_TICKS - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   deb;
    } deb_s;

    deb_s             s_d, s_q;
    logic [CNT_W-1:0] limit;
    logic             ring_s;

    assign ring_s = s_q.sync[SYNC_STAGES-1];

    always_comb begin
        case (dbsel)
            DBSEL_SHORT: limit = LIM_SHORT;
            DBSEL_MID:   limit = LIM_MID;
            default:     limit = LIM_LONG;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], ring_n};
        if (dbsel == DBSEL_BYPASS) begin
            s_d.deb = ring_s;
            s_d.cnt = '0;
        end else if (ring_s == s_q.deb) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (s_q.cnt >= limit) begin
                s_d.deb = ring_s;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sync <= '1;
            s_q.cnt  <= '0;
            s_q.deb  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ring_sync = ring_s;
    assign ring_deb  = s_q.deb;
endmodule

// File: rtl/ringwake_regs.sv
module ringwake_regs
    import ringwake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwr_state,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output ctrl_t      ctrl,
    output logic [5:0] levels,
    output logic       ac_lost
);
    typedef struct packed {
        ctrl_t      ctrl;
        logic [5:0] levels;
        logic       ac_lost;
        logic       s3_back;
        pwr_state_e prev;
    } regs_s;

    regs_s      s_d, s_q;
    pwr_state_e cur;
    logic       unused_wbits;

    assign cur          = pwr_state_e'(pwr_state);
    assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[3]};

    always_comb begin
        s_d = s_q;
        if (reg_we) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    s_d.ctrl.master_en = reg_wdata[0];
                    s_d.ctrl.pme_en    = reg_wdata[1];
                    s_d.ctrl.pso_en    = reg_wdata[2];
                    s_d.ctrl.dbsel     = reg_wdata[5:4];
                end
                ADDR_LEVEL: s_d.levels = reg_wdata[5:0];
                ADDR_STAT: begin
                    if (reg_wdata[0]) s_d.ac_lost = 1'b0;
                    if (reg_wdata[1]) s_d.s3_back = 1'b0;
                end
                default: ;
            endcase
        end
        // hardware sets take priority over software clears
        if (cur == PS_ACLOSS && s_q.prev != PS_ACLOSS) s_d.ac_lost = 1'b1;
        if (cur == PS_WORK && s_q.prev == PS_S3)       s_d.s3_back = 1'b1;
        s_d.prev = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl    <= CTRL_RST;
            s_q.levels  <= LEVEL_RST;
            s_q.ac_lost <= 1'b1;
            s_q.s3_back <= 1'b0;
            s_q.prev    <= PS_WORK;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = {2'b00, s_q.ctrl.dbsel, 1'b0, s_q.ctrl.pso_en,
                                     s_q.ctrl.pme_en, s_q.ctrl.master_en};
            ADDR_LEVEL: reg_rdata = {2'b00, s_q.levels};
            ADDR_STAT:  reg_rdata = {6'b0, s_q.s3_back, s_q.ac_lost};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign ctrl    = s_q.ctrl;
    assign levels  = s_q.levels;
    assign ac_lost = s_q.ac_lost;
endmodule

// File: rtl/ringwake_drive.sv
module ringwake_drive
    import ringwake_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ring_deb,
    input  logic                pme_en,
    input  logic                pso_en,
    input  logic                master_en,
    input  logic [1:0]          pwr_state,
    input  logic [3*NUM_PINS-1:0] levels,
    output logic                pme_evt,
    output logic                pso_evt,
    output logic [NUM_PINS-1:0] ctl_n
);
    typedef struct packed {
        logic                deb_prev;
        logic                pme;
        logic                pso;
        logic [NUM_PINS-1:0] ctl_n;
    } drv_s;

    drv_s                s_d, s_q;
    logic [NUM_PINS-1:0] lvl_sel;
    logic                fall;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        always_comb begin
            case (pwr_state_e'(pwr_state))
                PS_S3:     lvl_sel[k] = levels[k];
                PS_S5:     lvl_sel[k] = levels[NUM_PINS + k];
                PS_ACLOSS: lvl_sel[k] = levels[2*NUM_PINS + k];
                default:   lvl_sel[k] = 1'b1;
            endcase
        end
    end

    assign fall = s_q.deb_prev & ~ring_deb;

    always_comb begin
        s_d          = s_q;
        s_d.deb_prev = ring_deb;
        s_d.pme      = fall & pme_en;
        s_d.pso      = fall & pso_en;
        s_d.ctl_n    = master_en ? lvl_sel : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.deb_prev <= 1'b1;
            s_q.pme      <= 1'b0;
            s_q.pso      <= 1'b0;
            s_q.ctl_n    <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pme_evt = s_q.pme;
    assign pso_evt = s_q.pso;
    assign ctl_n   = s_q.ctl_n;
endmodule

// File: rtl/ringwake_pwrctl.sv
module ringwake_pwrctl
    import ringwake_pkg::*;
#(
    parameter int TICK_DIV    = 200,
    parameter int SHORT_TICKS = 200,
    parameter int MID_TICKS   = 2000,
    parameter int LONG_TICKS  = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_n,
    input  logic [1:0] pwr_state,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       pme_evt,
    output logic       pso_evt,
    output logic [1:0] ctl_n
);
    logic       tick;
    logic       ring_sync;
    logic       ring_deb;
    ctrl_t      ctrl;
    logic [5:0] levels;
    logic       ac_lost;

    ringwake_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    ringwake_debounce #(
        .SYNC_STAGES(SYNC_STAGES), .SHORT_TICKS(SHORT_TICKS),
        .MID_TICKS(MID_TICKS), .LONG_TICKS(LONG_TICKS)
    ) u_deb (
        .clk(clk), .rst_n(rst_n), .ring_n(ring_n), .tick(tick),
        .dbsel(ctrl.dbsel), .ring_sync(ring_sync), .ring_deb(ring_deb)
    );

    ringwake_regs u_regs (
        .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ctrl(ctrl), .levels(levels), .ac_lost(ac_lost)
    );

    ringwake_drive #(.NUM_PINS(2)) u_drive (
        .clk(clk), .rst_n(rst_n), .ring_deb(ring_deb),
        .pme_en(ctrl.pme_en), .pso_en(ctrl.pso_en), .master_en(ctrl.master_en),
        .pwr_state(pwr_state), .levels(levels),
        .pme_evt(pme_evt), .pso_evt(pso_evt), .ctl_n(ctl_n)
    );
endmodule

// File: rtl/ringwake_pwrctl_chk.sv
module ringwake_pwrctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pwr_state,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       clr_ac,
    input logic       pme_evt,
    input logic       pso_evt,
    input logic [1:0] ctl_n,
    input logic       pme_en,
    input logic       pso_en,
    input logic       master_en,
    input logic       ring_sync,
    input logic       ring_deb,
    input logic       ac_lost
);
    // R5
    pme_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pme_evt |=> !pme_evt);

    // R6
    pso_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pso_evt |=> !pso_evt);

    // R5
    pme_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pme_evt |-> ($past(pme_en) && !$past(ring_deb) && $past(ring_deb, 2)));

    // R6
    pso_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pso_evt |-> ($past(pso_en) && !$past(ring_deb) && $past(ring_deb, 2)));

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en || pwr_state == 2'b00) |=> (ctl_n == 2'b11));

    // R2
    deb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_deb != $past(ring_deb)) |-> ($past(ring_sync) == ring_deb));

    // R9
    aclost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd2 && clr_ac && pwr_state != 2'b11) |=> !ac_lost);

    // R9
    aclost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b11 && $past(pwr_state) != 2'b11) |=> ac_lost);
endmodule

bind ringwake_pwrctl ringwake_pwrctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state),
    .reg_we(reg_we), .reg_addr(reg_addr), .clr_ac(reg_wdata[0]),
    .pme_evt(pme_evt), .pso_evt(pso_evt), .ctl_n(ctl_n),
    .pme_en(ctrl.pme_en), .pso_en(ctrl.pso_en), .master_en(ctrl.master_en),
    .ring_sync(ring_sync), .ring_deb(ring_deb), .ac_lost(ac_lost)
);

// File: tb/ringwake_pwrctl_bench.sv
`timescale 1ns/1ps
module ringwake_pwrctl_bench;
    localparam int DIV = 4;
    localparam int T1  = 5;
    localparam int T2  = 10;
    localparam int T3  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring_n = 1'b1;
    logic [1:0] pwr_state = 2'b00;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pme_evt, pso_evt;
    logic [1:0] ctl_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ringwake_pwrctl #(.TICK_DIV(DIV), .SHORT_TICKS(T1), .MID_TICKS(T2),
                      .LONG_TICKS(T3), .SYNC_STAGES(2)) u_ringwake_pwrctl (
        .clk(clk), .rst_n(rst_n), .ring_n(ring_n), .pwr_state(pwr_state),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pme_evt(pme_evt), .pso_evt(pso_evt), .ctl_n(ctl_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic observe(input int win, output int np, output int ns,
                           output int fp, output int fs);
        np = 0; ns = 0; fp = -1; fs = -1;
        for (int c = 1; c <= win; c++) begin
            @(posedge clk); #1;
            if (pme_evt) begin np++; if (fp < 0) fp = c; end
            if (pso_evt) begin ns++; if (fs < 0) fs = c; end
        end
    endtask

    function automatic int ticks_for(input int sel);
        case (sel)
            1: return T1;
            2: return T2;
            3: return T3;
            default: return 0;
        endcase
    endfunction

    task automatic fall_test(input int sel, input int pe, input int se);
        int L, win, np, ns, fp, fs, lo, hi;
        L   = ticks_for(sel);
        win = (L == 0) ? 10 : L * DIV + 13;
        lo  = (L == 0) ? 4 : (L - 1) * DIV + 4;
        hi  = (L == 0) ? 4 : L * DIV + 3;
        wr(2'd0, {2'b00, 2'(sel), 1'b0, 1'(se), 1'(pe), 1'b0});
        @(negedge clk); ring_n = 1'b0;
        observe(win, np, ns, fp, fs);
        // R5 / R6: exactly one pulse per enabled falling edge
        chk($sformatf("R5 pme count sel=%0d en=%0d", sel, pe), np, pe);
        chk($sformatf("R6 pso count sel=%0d en=%0d", sel, se), ns, se);
        // R2 / R4: latency window
        if (pe != 0) chk_range($sformatf("R2 R4 pme latency sel=%0d", sel), fp, lo, hi);
        if (se != 0) chk_range($sformatf("R2 R4 pso latency sel=%0d", sel), fs, lo, hi);
        if (pe != 0 && se != 0) chk("R6 same-cycle pulses", fs, fp);
        @(negedge clk); ring_n = 1'b1;
        observe(win, np, ns, fp, fs);
        chk("R5 no pme on rising edge", np, 0);
        chk("R6 no pso on rising edge", ns, 0);
    endtask

    initial begin
        logic [7:0] v;
        int np, ns, fp, fs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl reset", int'(v), 8'h10);
        rd(2'd1, v); chk("R1 level reset", int'(v), 8'h0F);
        rd(2'd2, v); chk("R1 status reset", int'(v), 8'h01);
        rd(2'd3, v); chk("R1 addr3 reads zero", int'(v), 0);
        chk("R1 ctl_n reset", int'(ctl_n), 3);
        chk("R1 pme reset", int'(pme_evt), 0);
        chk("R1 pso reset", int'(pso_evt), 0);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R1 addr3 write ignored", int'(v), 0);
        rd(2'd0, v); chk("R1 addr3 write leaves ctrl", int'(v), 8'h10);
        rd(2'd1, v); chk("R1 addr3 write leaves level", int'(v), 8'h0F);

        // R9 AC-lost flag
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R9 write 0 keeps flag", int'(v[0]), 1);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R9 write 1 clears flag", int'(v[0]), 0);
        @(negedge clk);
        pwr_state = 2'b11; reg_addr = 2'd2; reg_wdata = 8'h01; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(2'd2, v); chk("R9 set wins over clear", int'(v[0]), 1);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R9 clear while staying in 11", int'(v[0]), 0);
        @(negedge clk); pwr_state = 2'b00;
        @(negedge clk); pwr_state = 2'b11;
        rd(2'd2, v); chk("R9 set on entry to 11", int'(v[0]), 1);

        // R10 back-from-S3 flag
        @(negedge clk); pwr_state = 2'b10;
        @(negedge clk); pwr_state = 2'b00;
        rd(2'd2, v); chk("R10 S5 to working does not set", int'(v[1]), 0);
        @(negedge clk); pwr_state = 2'b01;
        @(negedge clk); pwr_state = 2'b00;
        rd(2'd2, v); chk("R10 S3 to working sets", int'(v[1]), 1);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R10 write 1 clears", int'(v[1]), 0);

        // R2 R4 R5 R6 sweep of debounce select against enables
        for (int sel = 0; sel < 4; sel++)
            for (int en = 0; en < 4; en++)
                fall_test(sel, en & 1, (en >> 1) & 1);

        // R3 glitch rejection with the shortest interval
        wr(2'd0, 8'h16);
        @(negedge clk); ring_n = 1'b0;
        repeat (12) @(negedge clk);
        ring_n = 1'b1;
        observe(60, np, ns, fp, fs);
        chk("R3 glitch no pme", np, 0);
        chk("R3 glitch no pso", ns, 0);
        fall_test(1, 1, 1);

        // R7 R8 exhaustive sweep of state, master enable and level table
        for (int m = 0; m < 2; m++) begin
            wr(2'd0, 8'h10 | 8'(m));
            for (int st = 0; st < 4; st++) begin
                for (int lv = 0; lv < 64; lv++) begin
                    int exp;
                    wr(2'd1, 8'(lv));
                    @(negedge clk); pwr_state = 2'(st);
                    @(negedge clk); @(negedge clk);
                    if (m == 0 || st == 0) exp = 3;
                    else exp = (lv >> (2 * (st - 1))) & 3;
                    chk($sformatf("%s ctl_n m=%0d st=%0d lv=%0d",
                                  (m == 0 || st == 0) ? "R7" : "R8", m, st, lv),
                        int'(ctl_n), exp);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule